// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a byte-wide parallel flash. Software or a command engine first writes the program or sector-erase command sequence to the flash. After the last write pulse of that sequence it starts the poller with three things: the operation kind, the byte that was programmed, and an address. For an erase, the address must lie inside a sector that is being erased and not inside a protected one. The poller then issues status reads through a simple request/acknowledge read port. It reports the end of the operation with a one-cycle `done_o` pulse, a `fail_o` verdict and the final byte read from the flash.

Completion is judged on bit 7 of each status byte. Bit 7 can turn valid before the low seven bits do. For that reason, once bit 7 shows completion, the poller always makes one more read and takes that read as the real byte. Bit 5 of a status byte is the device's time-limit flag. When it is set on an incomplete read, the poller makes one re-read to tell a late finish apart from a real timeout. A programmable cap on the number of status reads covers a device that never answers.

Top module: `flash_poll_ctrl`

## Requirements
- R1: When the block is idle, a `start_i` pulse captures `op_erase_i`, `exp_data_i` and `poll_addr_i`. In the next cycle `busy_o` and `rd_req_o` are high and `rd_addr_o` equals the captured address.
- R2: A read request stays high, with `rd_addr_o` unchanged, until a cycle in which `rd_ack_i` is high. `rd_data_i` is taken in that same cycle. While the block is idle, `rd_req_o` is low.
- R3: For a program (`op_erase_i`=0), a status read means the operation is complete when its bit 7 equals bit 7 of the expected byte.
- R4: For an erase (`op_erase_i`=1), a status read means the operation is complete when its bit 7 is 1.
- R5: After a status read that shows completion, exactly one more read is made. The byte from that read is presented on `result_o`.
- R6: A program passes only if the byte from that extra read equals the expected byte in all 8 bits. Otherwise `fail_o` is set.
- R7: An erase passes only if bit 7 of the byte from that extra read is 1. Otherwise `fail_o` is set.
- R8: If a status read is incomplete and its bit 5 is 1, one re-read follows. If the re-read shows completion, the block continues as in R5. If not, the operation fails and `result_o` is the re-read byte.
- R9: After `MAX_POLLS` incomplete status reads, the last one having bit 5 at 0, the operation fails and `result_o` is that last byte. Re-reads and confirming reads do not count toward the cap.
- R10: When one status read meets several conditions, completion wins over bit 5, and bit 5 wins over the read cap.
- R11: `done_o` is high for exactly one cycle per operation and `busy_o` is low in that cycle. `fail_o` and `result_o` change only in a `done_o` cycle, and they hold their values until the next one.
- R12: A `start_i` pulse while `busy_o` is high is ignored. The captured address, operation kind and expected byte stay in use.
- R13: While reset is asserted and after it is released, `done_o`, `busy_o`, `rd_req_o` and `fail_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, single cycle |
| op_erase_i | input | 1 | Operation kind: 1 = erase, 0 = program |
| exp_data_i | input | 8 | Byte that was programmed |
| poll_addr_i | input | ADDR_W | Address used for the status reads |
| busy_o | output | 1 | An operation is being polled |
| rd_req_o | output | 1 | Read request to the flash port |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | 8 | Byte read from the flash |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Verdict of the last operation |
| result_o | output | 8 | Last byte read for the last operation |

## Verification
A single status read can carry the time-limit flag, and it can also be the read that reaches the poll cap or the one that shows completion. When the flag and the cap land on the same read, the block must make a re-read instead of failing at once. When completion and the flag land together, the flag must be ignored. The bench builds directed read sequences in which bit 5 or the completion value appears exactly on the `MAX_POLLS`-th status read, with the cap set small. Random sequences place the flag on arbitrary reads. Each outcome is checked against a reference function that applies the R10 priority order. That function returns the verdict, the result byte and the exact number of reads the flash port must serve.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int DATA_W  = 8;
  localparam int POLL_BIT = 7;
  localparam int TLIM_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_CONF  = 2'd3
  } fpc_state_e;
endpackage

// File: rtl/fpc_req_latch.sv
module fpc_req_latch
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              op_erase_q_o,
  output logic [DATA_W-1:0] exp_q_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_erase_q_o <= 1'b0;
      exp_q_o      <= '0;
      addr_q_o     <= '0;
    end else if (load_i) begin
      op_erase_q_o <= op_erase_i;
      exp_q_o      <= exp_i;
      addr_q_o     <= addr_i;
    end
  end
endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval (
  input  logic op_erase_i,
  input  logic exp_b7_i,
  input  logic dq7_i,
  input  logic dq5_i,
  output logic complete_o,
  output logic tlim_o
);
  // erase finishes on a 1, program finishes when bit 7 matches the written byte
  always_comb begin
    if (op_erase_i) complete_o = dq7_i;
    else            complete_o = (dq7_i == exp_b7_i);
    tlim_o = dq5_i;
  end
endmodule

// File: rtl/fpc_poll_counter.sv
module fpc_poll_counter #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // high while the read in flight is the last one allowed
  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/fpc_fsm.sv
module fpc_fsm
  import fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              complete_i,
  input  logic              tlim_i,
  input  logic              last_i,
  input  logic              op_erase_q_i,
  input  logic [DATA_W-1:0] exp_q_i,
  output logic              load_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] result_o
);
  fpc_state_e state_q, state_d;
  logic       fin, fin_fail;
  logic       done_q, fail_q;
  logic [DATA_W-1:0] result_q;

  always_comb begin
    state_d   = state_q;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    load_o    = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o    = 1'b1;
          cnt_clr_o = 1'b1;
          state_d   = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rd_ack_i) begin
          cnt_inc_o = 1'b1;
          if (complete_i)  state_d = ST_CONF;
          else if (tlim_i) state_d = ST_RECHK;
          else if (last_i) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_RECHK: begin
        if (rd_ack_i) begin
          if (complete_i) state_d = ST_CONF;
          else begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_CONF: begin
        if (rd_ack_i) begin
          fin = 1'b1;
          if (op_erase_q_i) fin_fail = ~rd_data_i[POLL_BIT];
          else              fin_fail = (rd_data_i != exp_q_i);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q   <= 1'b0;
      result_q <= '0;
    end else if (fin) begin
      fail_q   <= fin_fail;
      result_q <= rd_data_i;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign rd_req_o = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign result_o = result_q;
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [7:0]        exp_data_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [7:0]        result_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              load, cnt_clr, cnt_inc, last_poll;
  logic              op_erase_q;
  logic [DATA_W-1:0] exp_q;
  logic              complete, tlim;

  fpc_req_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .load_i       (load),
    .op_erase_i   (op_erase_i),
    .exp_i        (exp_data_i),
    .addr_i       (poll_addr_i),
    .op_erase_q_o (op_erase_q),
    .exp_q_o      (exp_q),
    .addr_q_o     (rd_addr_o)
  );

  fpc_status_eval u_eval (
    .op_erase_i (op_erase_q),
    .exp_b7_i   (exp_q[POLL_BIT]),
    .dq7_i      (rd_data_i[POLL_BIT]),
    .dq5_i      (rd_data_i[TLIM_BIT]),
    .complete_o (complete),
    .tlim_o     (tlim)
  );

  fpc_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (last_poll)
  );

  fpc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start_i),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .complete_i   (complete),
    .tlim_i       (tlim),
    .last_i       (last_poll),
    .op_erase_q_i (op_erase_q),
    .exp_q_i      (exp_q),
    .load_o       (load),
    .cnt_clr_o    (cnt_clr),
    .cnt_inc_o    (cnt_inc),
    .busy_o       (busy_o),
    .rd_req_o     (rd_req_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .result_o     (result_o)
  );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int ADDR_W    = 21,
  parameter int MAX_POLLS = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              done_o,
  input logic              fail_o,
  input logic [7:0]        result_o
);
  localparam int CW = $clog2(MAX_POLLS + 4);

  logic [CW-1:0] acks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      acks_q <= '0;
    else if (start_i && !busy_o)     acks_q <= '0;
    else if (rd_req_o && rd_ack_i)   acks_q <= acks_q + 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o); // R2
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R12
  AST_VERDICT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fail_o) || !$stable(result_o)) |-> done_o); // R11
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acks_q <= CW'(MAX_POLLS + 2)); // R9
endmodule

bind flash_poll_ctrl fpc_checker #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .result_o  (result_o)
);

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;
  localparam int AW = 21;
  localparam int MP = 8;
  localparam int SEQ_N = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          op_erase_i;
  logic [7:0]    exp_data_i;
  logic [AW-1:0] poll_addr_i;
  logic          busy_o, rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i;
  logic [7:0]    rd_data_i;
  logic          done_o, fail_o;
  logic [7:0]    result_o;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .exp_data_i(exp_data_i), .poll_addr_i(poll_addr_i), .busy_o(busy_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .fail_o(fail_o), .result_o(result_o)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [7:0]    seq [SEQ_N];
  int            idx;
  int            dly;
  int            addr_bad;
  logic [AW-1:0] cur_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // flash model: serves the scripted bytes, random wait states
  always @(negedge clk) begin
    if (rd_req_o) begin
      if (dly == 0) begin
        rd_ack_i  = 1'b1;
        rd_data_i = (idx < SEQ_N) ? seq[idx] : 8'h00;
        if (rd_addr_o !== cur_addr) addr_bad++;
        idx++;
        dly = int'($urandom % 3);
      end else begin
        rd_ack_i = 1'b0;
        dly--;
      end
    end else begin
      rd_ack_i = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic is_cpl(input logic op, input logic [7:0] ex, input logic [7:0] b);
    return op ? b[7] : (b[7] == ex[7]);
  endfunction

  function automatic logic [7:0] busy_b(input logic op, input logic [7:0] ex, input logic t5);
    logic [7:0] b;
    b = {op ? 1'b0 : ~ex[7], 7'h1A};
    b[5] = t5;
    return b;
  endfunction

  function automatic logic [7:0] cpl_b(input logic op, input logic [7:0] ex);
    return op ? 8'h80 : {ex[7], 7'h00};
  endfunction

  // reference: returns reads served, verdict and result byte
  function automatic void model(input logic op, input logic [7:0] ex,
                                output int nreads, output logic f, output logic [7:0] r);
    int i;
    int polls;
    logic [7:0] b;
    i = 0; polls = 0; f = 1'b0; r = 8'h00;
    while (i < SEQ_N - 4) begin
      b = seq[i]; i++; polls++;
      if (is_cpl(op, ex, b)) begin
        r = seq[i]; i++;
        f = op ? ~r[7] : (r != ex);
        break;
      end
      if (b[5]) begin
        b = seq[i]; i++;
        if (is_cpl(op, ex, b)) begin
          r = seq[i]; i++;
          f = op ? ~r[7] : (r != ex);
        end else begin
          r = b; f = 1'b1;
        end
        break;
      end
      if (polls == MP) begin
        r = b; f = 1'b1;
        break;
      end
    end
    nreads = i;
  endfunction

  task automatic fill_busy(input logic op, input logic [7:0] ex);
    for (int j = 0; j < SEQ_N; j++) seq[j] = busy_b(op, ex, 1'b0);
  endtask

  task automatic fill_random(input logic op, input logic [7:0] ex);
    int k;
    k = int'($urandom % (MP + 3));
    for (int j = 0; j < SEQ_N; j++) begin
      if (j < k) seq[j] = busy_b(op, ex, ($urandom % 5) == 0);
      else if (j == k) begin
        seq[j] = cpl_b(op, ex);
        seq[j][6:0] = 7'($urandom);
      end else if (j == k + 1) begin
        if (op) seq[j] = (($urandom % 5) != 0) ? 8'hFF : 8'($urandom);
        else    seq[j] = (($urandom % 5) != 0) ? ex : (ex ^ (8'h01 << ($urandom % 8)));
      end else seq[j] = 8'($urandom);
    end
  endtask

  task automatic run_case(input logic op, input logic [7:0] ex, input logic [AW-1:0] addr,
                          input bit stray, input string req);
    int   nreads;
    logic f;
    logic [7:0] r;
    int   cyc;
    model(op, ex, nreads, f, r);
    idx = 0; addr_bad = 0; dly = int'($urandom % 3); cur_addr = addr;
    @(negedge clk);
    start_i = 1'b1; op_erase_i = op; exp_data_i = ex; poll_addr_i = addr;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && rd_addr_o === addr, "R1", "busy/addr after start", rd_addr_o, addr);
    if (stray) begin
      start_i = 1'b1; op_erase_i = ~op; exp_data_i = ~ex; poll_addr_i = ~addr;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o === 1'b1, req, "done seen", done_o, 1);
    chk(fail_o === f, req, "fail verdict", fail_o, f);
    chk(result_o === r, req, "result byte", result_o, r);
    chk(idx == nreads, req, "reads served", idx, nreads);
    chk(addr_bad == 0, stray ? "R12" : "R2", "read address", addr_bad, 0);
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0 && fail_o === f && result_o === r,
        "R11", "pulse width / hold", {done_o, busy_o}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0101));
    rst_n = 1'b0; start_i = 1'b0; op_erase_i = 1'b0; exp_data_i = 8'h00;
    poll_addr_i = '0; rd_ack_i = 1'b0; rd_data_i = 8'h00;
    idx = 0; dly = 0; addr_bad = 0; cur_addr = '0;
    for (int j = 0; j < SEQ_N; j++) seq[j] = 8'h00;
    repeat (3) @(negedge clk);
    chk(done_o === 0 && busy_o === 0 && rd_req_o === 0 && fail_o === 0, "R13", "in reset",
        {done_o, busy_o, rd_req_o, fail_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done_o === 0 && busy_o === 0 && rd_req_o === 0 && fail_o === 0, "R13", "after reset",
        {done_o, busy_o, rd_req_o, fail_o}, 0);

    // R3 R5 R6: program completes after two busy reads, byte matches
    fill_busy(1'b0, 8'hA5); seq[2] = cpl_b(1'b0, 8'hA5); seq[3] = 8'hA5;
    run_case(1'b0, 8'hA5, 21'h01234, 1'b0, "R3");
    // R4 R7: erase passes
    fill_busy(1'b1, 8'h00); seq[3] = 8'h80; seq[4] = 8'hFF;
    run_case(1'b1, 8'h00, 21'h1F000, 1'b0, "R4");
    // R6: program, bit 7 of 0 done, confirm mismatches
    fill_busy(1'b0, 8'h3C); seq[0] = cpl_b(1'b0, 8'h3C); seq[1] = 8'h3D;
    run_case(1'b0, 8'h3C, 21'h00010, 1'b0, "R6");
    // R7: erase confirm with bit 7 low
    fill_busy(1'b1, 8'h00); seq[0] = 8'h80; seq[1] = 8'h7F;
    run_case(1'b1, 8'h00, 21'h10000, 1'b0, "R7");
    // R8: time flag, re-read shows done
    fill_busy(1'b0, 8'hC3); seq[1] = busy_b(1'b0, 8'hC3, 1'b1);
    seq[2] = cpl_b(1'b0, 8'hC3); seq[3] = 8'hC3;
    run_case(1'b0, 8'hC3, 21'h0ABCD, 1'b0, "R8");
    // R8: time flag, re-read still busy
    fill_busy(1'b0, 8'hC3); seq[1] = busy_b(1'b0, 8'hC3, 1'b1);
    run_case(1'b0, 8'hC3, 21'h0ABCE, 1'b0, "R8");
    // R10: time flag lands on the last allowed poll
    fill_busy(1'b1, 8'h00); seq[MP-1] = busy_b(1'b1, 8'h00, 1'b1);
    seq[MP] = 8'h80; seq[MP+1] = 8'hFF;
    run_case(1'b1, 8'h00, 21'h12345, 1'b0, "R10");
    // R10: completion with time flag set is still completion
    fill_busy(1'b0, 8'h5A); seq[MP-1] = {1'b0, 7'h20}; seq[MP] = 8'h5A;
    run_case(1'b0, 8'h5A, 21'h00777, 1'b0, "R10");
    // R9: cap reached
    fill_busy(1'b1, 8'h00);
    run_case(1'b1, 8'h00, 21'h0FFFF, 1'b0, "R9");
    // R12: start while busy
    fill_busy(1'b0, 8'hA5); seq[2] = cpl_b(1'b0, 8'hA5); seq[3] = 8'hA5;
    run_case(1'b0, 8'hA5, 21'h05555, 1'b1, "R12");

    for (int n = 0; n < 60; n++) begin
      logic op;
      logic [7:0] ex;
      op = 1'($urandom);
      ex = 8'($urandom);
      fill_random(op, ex);
      run_case(op, ex, AW'($urandom), (($urandom % 4) == 0), op ? "R4" : "R3");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule